// File: doc/BRIEF.md
# Host FIFO Block Transfer Sequencer

This block moves data between an external host (a processor or a DMA master) and an internal word FIFO in fixed-size blocks. Software programs a 16-bit control register and a 16-bit low-address register, then pulses a start strobe. The controller latches the configuration and runs exactly one block. In host-write mode the host pushes the block into the FIFO, and a downstream sink drains the FIFO. In read mode the FIFO is first filled, either from external memory through a simple request/acknowledge word port or from an internal packet unit through a valid/ready port, and the host then pulls the block out.

The host request is raised only when a whole block can be moved. In memory mode the controller keeps a 20-bit word pointer. The pointer is formed from four high bits in the control register and the low-address register. It advances by one for each word fetched and wraps modulo 2^20. It is written back into those two registers, so it can be read back at any time and the next block continues from where the last one ended.

Top module: `hdma_block_ctrl`

## Requirements
- R1: After reset, the control readback is 0x0200 and the low-address readback is 0, and busy, cfg_err, host_req, mem_req, pu_ready and fifo_level are all 0. Control layout: bits [13:10] are the high address bits, [9:4] the size code, bit 3 the source select (1 = packet unit), bit 2 the direction (1 = host writes). Bits 15, 14, 1 and 0 always read 0.
- R2: The size code gives the block length. Codes 1 to 31 mean that many words, and any code with bit 5 set means 32 words. Each transfer moves exactly that many words on the host side and on the fill side, and then busy and host_req drop.
- R3: A start with size code 0 sets cfg_err, leaves busy at 0 and issues no memory, packet or host request.
- R4: A start with source select 1 and direction 1 sets cfg_err and stays idle. Any legal start clears cfg_err.
- R5: In read mode, host_req rises only after the fill is complete and fifo_level equals at least the block length. Each accepted host_rd returns its word on rd_data one cycle later. host_req falls on the clock edge that accepts the last word.
- R6: In write mode, host_req is asserted only while the free FIFO space (64 minus fifo_level) is at least the block length. Host words enter the FIFO in order and leave through the sink port in the same order.
- R7: In memory mode, mem_addr equals {control[13:10], low-address} and advances by 1 for each acknowledged word, wrapping modulo 2^20. The advanced pointer is visible in both readbacks. mem_req stays low once the block has been fetched.
- R8: In packet mode, pu_ready accepts exactly one block of words, mem_req stays low, and the pointer does not change.
- R9: The configuration is latched at start. While busy, writes to both registers and further start pulses are ignored.
- R10: The sink port pops a word one cycle before it appears on rd_data. A sink pop in the same cycle as a host write leaves fifo_level unchanged. Sink pops are refused while a read-mode block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_ctrl | input | 1 | Write strobe for the control register |
| reg_wr_lo | input | 1 | Write strobe for the low-address register |
| reg_wdata | input | 16 | Register write data |
| ctrl_rdback | output | 16 | Control register contents |
| lo_rdback | output | 16 | Low-address register contents |
| start | input | 1 | Start one block with the current registers |
| busy | output | 1 | A block is in progress |
| cfg_err | output | 1 | The last start had an illegal configuration |
| host_req | output | 1 | A whole block can be moved by the host |
| host_wr | input | 1 | Host write strobe (write mode) |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | Host read strobe (read mode) |
| rd_data | output | DATA_W | FIFO read data, valid one cycle after a pop |
| sink_rd | input | 1 | Downstream drain strobe |
| fifo_level | output | $clog2(FIFO_DEPTH)+1 | Words held in the FIFO |
| mem_req | output | 1 | Memory word request |
| mem_addr | output | 20 | Memory word address |
| mem_ack | input | 1 | Memory acknowledge, with data |
| mem_rdata | input | DATA_W | Memory read data |
| pu_ready | output | 1 | Packet unit may deliver a word |
| pu_valid | input | 1 | Packet unit word valid |
| pu_data | input | DATA_W | Packet unit data |

## Verification
In write mode, a host push and a sink drain can land on the same clock edge. The FIFO then has to count one in and one out, and deliver the oldest word, not the new one. The bench provokes this by filling the FIFO to full with two write blocks and starting a one-word block that must hold its request until the sink frees a slot. It then issues the host word and a sink pop in the same cycle. The result is judged by an unchanged fifo_level, by the popped word, and by the complete drain order that follows. All 63 read-from-memory size codes are also swept with the sink strobe held high, to show that draining is locked out while a read block is busy.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  localparam int CTRL_W   = 16;
  localparam int LO_W     = 16;
  localparam int HI_W     = 4;
  localparam int PTR_W    = HI_W + LO_W;
  localparam int CODE_W   = 6;
  localparam int BLK_W    = 6;
  localparam int HI_LSB   = 10;
  localparam int CODE_LSB = 4;
  localparam int SRC_BIT  = 3;
  localparam int DIR_BIT  = 2;
  localparam logic [BLK_W-1:0] MAX_BLK = BLK_W'(32);

  typedef struct packed {
    logic [HI_W-1:0]   hi;
    logic [CODE_W-1:0] code;
    logic              src_pu;
    logic              host_wr_dir;
  } xfer_cfg_t;

  localparam xfer_cfg_t CFG_RESET = '{hi: '0, code: CODE_W'(32), src_pu: 1'b0, host_wr_dir: 1'b0};

  function automatic logic [BLK_W-1:0] blk_words(input logic [CODE_W-1:0] c);
    return c[CODE_W-1] ? MAX_BLK : {1'b0, c[CODE_W-2:0]};
  endfunction

  function automatic logic [CTRL_W-1:0] pack_ctrl(input xfer_cfg_t c);
    logic [CTRL_W-1:0] v;
    v = '0;
    v[HI_LSB +: HI_W]     = c.hi;
    v[CODE_LSB +: CODE_W] = c.code;
    v[SRC_BIT]            = c.src_pu;
    v[DIR_BIT]            = c.host_wr_dir;
    return v;
  endfunction

  function automatic xfer_cfg_t unpack_ctrl(input logic [CTRL_W-1:0] v);
    xfer_cfg_t c;
    c.hi          = v[HI_LSB +: HI_W];
    c.code        = v[CODE_LSB +: CODE_W];
    c.src_pu      = v[SRC_BIT];
    c.host_wr_dir = v[DIR_BIT];
    return c;
  endfunction
endpackage

// File: rtl/hdma_regs.sv
module hdma_regs
  import hdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_lo,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              lock,
  input  logic              ptr_inc,
  output xfer_cfg_t         cfg,
  output logic [LO_W-1:0]   lo
);
  logic [PTR_W-1:0] ptr_next;

  assign ptr_next = {cfg.hi, lo} + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
      lo  <= '0;
    end else if (ptr_inc) begin
      cfg.hi <= ptr_next[PTR_W-1:LO_W];
      lo     <= ptr_next[LO_W-1:0];
    end else if (!lock) begin
      if (wr_ctrl) cfg <= unpack_ctrl(wdata);
      if (wr_lo)   lo  <= wdata[LO_W-1:0];
    end
  end

  // R9: a busy block freezes the programmed fields
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    lock |=> (cfg.code == $past(cfg.code)) && (cfg.src_pu == $past(cfg.src_pu))
             && (cfg.host_wr_dir == $past(cfg.host_wr_dir)));
endmodule

// File: rtl/hdma_fifo.sv
module hdma_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) store[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop) rdata <= store[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      level <= level + LW'(push) - LW'(pop);
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (level < LW'(DEPTH)));
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> (level != '0));
endmodule

// File: rtl/hdma_seq.sv
module hdma_seq
  import hdma_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  xfer_cfg_t     cfg,
  input  logic [LW-1:0] level,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          sink_rd,
  input  logic          mem_ack,
  input  logic          pu_valid,
  output logic          busy,
  output logic          err,
  output logic          host_req,
  output logic          mem_req,
  output logic          pu_ready,
  output logic          src_pu,
  output logic          push,
  output logic          push_host,
  output logic          pop,
  output logic          ptr_inc
);
  logic             dir_q;
  logic [BLK_W-1:0] blk_q, fcnt_q, hcnt_q;

  logic             busy_d, err_d, dir_d, src_d, hreq_d, fill_d;
  logic [BLK_W-1:0] blk_d, fcnt_d, hcnt_d;
  logic             go, legal, fill_acc, host_pop, sink_pop, host_acc, fill_done;
  logic [LW-1:0]    lvl_n;

  always_comb begin
    go        = start && !busy;
    legal     = (cfg.code != '0) && !(cfg.src_pu && cfg.host_wr_dir);
    fill_acc  = (mem_req && mem_ack) || (pu_ready && pu_valid);
    push_host = host_req && dir_q && host_wr;
    host_pop  = host_req && !dir_q && host_rd;
    sink_pop  = sink_rd && (level != '0) && !(busy && !dir_q);
    host_acc  = push_host || host_pop;
    push      = fill_acc || push_host;
    pop       = host_pop || sink_pop;
    ptr_inc   = mem_req && mem_ack;
    lvl_n     = level + LW'(push) - LW'(pop);

    busy_d = busy;
    err_d  = err;
    dir_d  = dir_q;
    src_d  = src_pu;
    blk_d  = blk_q;
    fcnt_d = fcnt_q;
    hcnt_d = hcnt_q;
    if (go) begin
      err_d = !legal;
      if (legal) begin
        busy_d = 1'b1;
        dir_d  = cfg.host_wr_dir;
        src_d  = cfg.src_pu;
        blk_d  = blk_words(cfg.code);
        fcnt_d = '0;
        hcnt_d = '0;
      end
    end else if (busy) begin
      if (fill_acc) fcnt_d = fcnt_q + BLK_W'(1);
      if (host_acc) hcnt_d = hcnt_q + BLK_W'(1);
      if (host_acc && (hcnt_q + BLK_W'(1) == blk_q)) busy_d = 1'b0;
    end

    fill_done = dir_d || (fcnt_d == blk_d);
    fill_d    = busy_d && !dir_d && (fcnt_d < blk_d) && (lvl_n < LW'(DEPTH));
    hreq_d    = busy_d && (hcnt_d < blk_d) &&
                (host_req || (dir_d ? ((LW'(DEPTH) - lvl_n) >= LW'(blk_d))
                                    : (fill_done && (lvl_n >= LW'(blk_d)))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      err      <= 1'b0;
      dir_q    <= 1'b0;
      src_pu   <= 1'b0;
      blk_q    <= MAX_BLK;
      fcnt_q   <= '0;
      hcnt_q   <= '0;
      host_req <= 1'b0;
      mem_req  <= 1'b0;
      pu_ready <= 1'b0;
    end else begin
      busy     <= busy_d;
      err      <= err_d;
      dir_q    <= dir_d;
      src_pu   <= src_d;
      blk_q    <= blk_d;
      fcnt_q   <= fcnt_d;
      hcnt_q   <= hcnt_d;
      host_req <= hreq_d;
      mem_req  <= fill_d && !src_d;
      pu_ready <= fill_d && src_d;
    end
  end

  a_r3_zero_code: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cfg.code == '0) |=> (err && !busy));
  a_r4_pu_write_illegal: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cfg.src_pu && cfg.host_wr_dir) |=> (err && !busy));
  a_r5_read_req_full: assert property (@(posedge clk) disable iff (rst)
    ($rose(host_req) && !dir_q) |-> (level >= LW'(blk_q)));
  a_r6_write_req_room: assert property (@(posedge clk) disable iff (rst)
    ($rose(host_req) && dir_q) |-> ((LW'(DEPTH) - level) >= LW'(blk_q)));
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (rst)
    (mem_req || pu_ready) |-> (fcnt_q < blk_q));
  a_r2_host_bound: assert property (@(posedge clk) disable iff (rst)
    host_req |-> (hcnt_q < blk_q));
endmodule

// File: rtl/hdma_block_ctrl.sv
module hdma_block_ctrl
  import hdma_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr_ctrl,
  input  logic                          reg_wr_lo,
  input  logic [15:0]                   reg_wdata,
  output logic [15:0]                   ctrl_rdback,
  output logic [15:0]                   lo_rdback,
  input  logic                          start,
  output logic                          busy,
  output logic                          cfg_err,
  output logic                          host_req,
  input  logic                          host_wr,
  input  logic [DATA_W-1:0]             host_wdata,
  input  logic                          host_rd,
  output logic [DATA_W-1:0]             rd_data,
  input  logic                          sink_rd,
  output logic [$clog2(FIFO_DEPTH):0]   fifo_level,
  output logic                          mem_req,
  output logic [19:0]                   mem_addr,
  input  logic                          mem_ack,
  input  logic [DATA_W-1:0]             mem_rdata,
  output logic                          pu_ready,
  input  logic                          pu_valid,
  input  logic [DATA_W-1:0]             pu_data
);
  localparam int LW = $clog2(FIFO_DEPTH) + 1;

  xfer_cfg_t       cfg;
  logic [LO_W-1:0] lo;
  logic            src_pu, push, push_host, pop, ptr_inc;
  logic [DATA_W-1:0] push_data;

  hdma_regs u_regs (
    .clk(clk), .rst(rst), .wr_ctrl(reg_wr_ctrl), .wr_lo(reg_wr_lo),
    .wdata(reg_wdata), .lock(busy), .ptr_inc(ptr_inc), .cfg(cfg), .lo(lo)
  );

  hdma_seq #(.DEPTH(FIFO_DEPTH), .LW(LW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cfg(cfg), .level(fifo_level),
    .host_wr(host_wr), .host_rd(host_rd), .sink_rd(sink_rd),
    .mem_ack(mem_ack), .pu_valid(pu_valid),
    .busy(busy), .err(cfg_err), .host_req(host_req), .mem_req(mem_req),
    .pu_ready(pu_ready), .src_pu(src_pu), .push(push), .push_host(push_host),
    .pop(pop), .ptr_inc(ptr_inc)
  );

  assign push_data = push_host ? host_wdata : (src_pu ? pu_data : mem_rdata);

  hdma_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata(push_data), .pop(pop),
    .rdata(rd_data), .level(fifo_level)
  );

  assign ctrl_rdback = pack_ctrl(cfg);
  assign lo_rdback   = lo;
  assign mem_addr    = {cfg.hi, lo};

  a_r7_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (mem_addr == $past(mem_addr) + 20'd1));
  a_r8_pu_excl: assert property (@(posedge clk) disable iff (rst)
    pu_ready |-> !mem_req);
endmodule

// File: tb/hdma_block_ctrl_bench.sv
module hdma_block_ctrl_bench;
  localparam int DW = 16;
  localparam int LW = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr_ctrl = 0, reg_wr_lo = 0, start = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] ctrl_rdback, lo_rdback;
  logic busy, cfg_err, host_req, mem_req, mem_ack, pu_ready, pu_valid;
  logic host_wr = 0, host_rd = 0, sink_rd = 0, pu_en = 0;
  logic [DW-1:0] host_wdata = '0, rd_data, mem_rdata, pu_data;
  logic [LW-1:0] fifo_level;
  logic [19:0] mem_addr;

  int checks = 0, fails = 0;
  logic [31:0] tick = 0, acks = 0;
  logic [15:0] pu_cnt = 0;
  logic mem_seen = 0;

  hdma_block_ctrl u_hdma_block_ctrl (
    .clk(clk), .rst(rst), .reg_wr_ctrl(reg_wr_ctrl), .reg_wr_lo(reg_wr_lo),
    .reg_wdata(reg_wdata), .ctrl_rdback(ctrl_rdback), .lo_rdback(lo_rdback),
    .start(start), .busy(busy), .cfg_err(cfg_err), .host_req(host_req),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .rd_data(rd_data), .sink_rd(sink_rd), .fifo_level(fifo_level),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .pu_ready(pu_ready), .pu_valid(pu_valid),
    .pu_data(pu_data)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return a[15:0] ^ 16'h5A3C ^ {12'h0, a[19:16]};
  endfunction

  function automatic logic [15:0] mk(input logic [3:0] hi, input logic [5:0] code,
                                     input logic src, input logic dir);
    return {2'b00, hi, code, src, dir, 2'b00};
  endfunction

  assign mem_ack   = mem_req & ~tick[1];
  assign mem_rdata = mem_word(mem_addr);
  assign pu_valid  = pu_en;
  assign pu_data   = pu_cnt;

  always @(posedge clk) begin
    tick <= tick + 1;
    if (mem_req && mem_ack) acks <= acks + 1;
    if (pu_valid && pu_ready) pu_cnt <= pu_cnt + 1;
    if (mem_req && !rst) mem_seen <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_ctrl(input logic [15:0] v);
    @(negedge clk); reg_wdata = v; reg_wr_ctrl = 1;
    @(negedge clk); reg_wr_ctrl = 0;
  endtask

  task automatic do_start(input logic [15:0] v);
    reg_ctrl(v);
    start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_req();
    int w = 0;
    while (!host_req && w < 300) begin @(negedge clk); w++; end
  endtask

  initial begin
    logic [19:0] ptr;
    logic [15:0] base, rb_c, rb_l, expw;
    int blk;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_rdback == 16'h0200, "R1", "ctrl reset", ctrl_rdback, 16'h0200);
    chk(lo_rdback == 0, "R1", "lo reset", lo_rdback, 0);
    chk(!busy && !cfg_err && !host_req && !mem_req && !pu_ready && fifo_level == 0,
        "R1", "outputs idle", {busy, cfg_err, host_req, mem_req, pu_ready}, 0);

    // R3 zero size code
    do_start(mk(4'h0, 6'd0, 1'b0, 1'b0));
    chk(cfg_err == 1, "R3", "err on code 0", cfg_err, 1);
    chk(busy == 0, "R3", "idle on code 0", busy, 0);
    repeat (3) @(negedge clk);
    chk(!mem_req && !host_req && !pu_ready, "R3", "no requests",
        {mem_req, host_req, pu_ready}, 0);
    do_start(mk(4'h0, 6'd0, 1'b0, 1'b1));
    chk(cfg_err && !busy && !host_req, "R3", "code 0 write mode", {cfg_err, busy, host_req}, 3'b100);

    // R4 packet source with host-write direction
    do_start(mk(4'h0, 6'd5, 1'b1, 1'b1));
    chk(cfg_err == 1, "R4", "err on pu+write", cfg_err, 1);
    repeat (2) @(negedge clk);
    chk(!busy && !host_req && !pu_ready, "R4", "stays idle", {busy, host_req, pu_ready}, 0);

    // R2/R5/R7/R10 sweep of all codes, memory to host, sink strobe held
    ptr = 20'hFFF00;
    @(negedge clk); reg_wdata = 16'hFF00; reg_wr_lo = 1;
    @(negedge clk); reg_wr_lo = 0;
    sink_rd = 1;
    for (int c = 1; c < 64; c++) begin
      blk  = (c >= 32) ? 32 : c;
      base = acks[15:0];
      do_start(mk(ptr[19:16], 6'(c), 1'b0, 1'b0));
      if (c == 1) chk(cfg_err == 0, "R4", "legal start clears err", cfg_err, 0);
      wait_req();
      chk(host_req == 1, "R5", "read request raised", host_req, 1);
      chk(fifo_level == LW'(blk), "R10", "full block held, sink locked out", fifo_level, blk);
      chk(acks[15:0] - base == 16'(blk), "R2", "words fetched", acks[15:0] - base, blk);
      chk(mem_req == 0, "R7", "fetch stops at block", mem_req, 0);
      for (int k = 0; k < blk; k++) begin
        @(negedge clk); host_rd = 1;
        @(negedge clk); host_rd = 0;
        expw = mem_word(ptr + 20'(k));
        chk(rd_data == expw, "R7", "memory word order", rd_data, expw);
      end
      chk(!host_req && !busy, "R5", "request drops after block", {host_req, busy}, 0);
      ptr = ptr + 20'(blk);
      chk({ctrl_rdback[13:10], lo_rdback} == ptr, "R7", "pointer writeback/wrap",
          {ctrl_rdback[13:10], lo_rdback}, ptr);
    end
    sink_rd = 0;

    // R8 packet unit source
    pu_en = 1;
    @(negedge clk);
    mem_seen = 0;
    foreach (blk_codes[i]) ;
    for (int t = 0; t < 2; t++) begin
      logic [5:0] code;
      code = (t == 0) ? 6'd5 : 6'd40;
      blk  = (t == 0) ? 5 : 32;
      base = pu_cnt;
      do_start(mk(ptr[19:16], code, 1'b1, 1'b0));
      wait_req();
      chk(host_req && fifo_level == LW'(blk), "R8", "packet block held", fifo_level, blk);
      chk(pu_cnt - base == 16'(blk), "R2", "packet words accepted", pu_cnt - base, blk);
      chk(pu_ready == 0, "R8", "pu_ready drops", pu_ready, 0);
      for (int k = 0; k < blk; k++) begin
        @(negedge clk); host_rd = 1;
        @(negedge clk); host_rd = 0;
        chk(rd_data == base + 16'(k), "R8", "packet word order", rd_data, base + 16'(k));
      end
      chk(!busy && mem_seen == 0, "R8", "no memory traffic", {busy, mem_seen}, 0);
      chk({ctrl_rdback[13:10], lo_rdback} == ptr, "R8", "pointer unchanged",
          {ctrl_rdback[13:10], lo_rdback}, ptr);
    end
    pu_en = 0;

    // R1 reserved bits read zero
    reg_ctrl(16'hFFFF);
    chk(ctrl_rdback == 16'h3FFC, "R1", "reserved bits zero", ctrl_rdback, 16'h3FFC);

    // R6 host write blocks
    do_start(mk(4'h0, 6'd32, 1'b0, 1'b1));
    chk(host_req == 1, "R6", "room for block", host_req, 1);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk); host_wr = 1; host_wdata = 16'h1000 + 16'(k);
    end
    @(negedge clk); host_wr = 0;
    chk(fifo_level == 32 && !busy && !host_req, "R2", "write block of 32", fifo_level, 32);
    do_start(mk(4'h0, 6'd63, 1'b0, 1'b1));
    chk(host_req == 1, "R6", "exact room boundary", host_req, 1);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk); host_wr = 1; host_wdata = 16'h2000 + 16'(k);
    end
    @(negedge clk); host_wr = 0;
    chk(fifo_level == 64, "R6", "fifo full", fifo_level, 64);
    do_start(mk(4'h0, 6'd1, 1'b0, 1'b1));
    repeat (4) @(negedge clk);
    chk(busy && !host_req, "R6", "no room, request held low", {busy, host_req}, 2'b10);

    // R9 writes and start ignored while busy
    rb_c = ctrl_rdback; rb_l = lo_rdback;
    @(negedge clk); reg_wdata = 16'h1234; reg_wr_ctrl = 1; reg_wr_lo = 1;
    @(negedge clk); reg_wr_ctrl = 0; reg_wr_lo = 0; start = 1;
    @(negedge clk); start = 0;
    chk(ctrl_rdback == rb_c, "R9", "ctrl write ignored", ctrl_rdback, rb_c);
    chk(lo_rdback == rb_l, "R9", "lo write ignored", lo_rdback, rb_l);
    chk(busy && !cfg_err && !host_req, "R9", "start ignored", {busy, cfg_err, host_req}, 3'b100);

    @(negedge clk); sink_rd = 1;
    @(negedge clk); sink_rd = 0;
    chk(rd_data == 16'h1000, "R10", "sink first word", rd_data, 16'h1000);
    chk(fifo_level == 63 && host_req, "R6", "request after slot frees", fifo_level, 63);

    // R10 concurrent host write and sink drain
    @(negedge clk); host_wr = 1; host_wdata = 16'hBEEF; sink_rd = 1;
    @(negedge clk); host_wr = 0; sink_rd = 0;
    chk(fifo_level == 63, "R10", "level unchanged", fifo_level, 63);
    chk(rd_data == 16'h1001, "R10", "oldest word popped", rd_data, 16'h1001);
    chk(!busy && !host_req, "R2", "one-word block done", {busy, host_req}, 0);
    for (int k = 0; k < 63; k++) begin
      @(negedge clk); sink_rd = 1;
      @(negedge clk); sink_rd = 0;
      expw = (k < 30) ? 16'h1002 + 16'(k) : (k < 62) ? 16'h2000 + 16'(k - 30) : 16'hBEEF;
      chk(rd_data == expw, "R6", "drain order", rd_data, expw);
    end
    chk(fifo_level == 0, "R10", "fifo drained", fifo_level, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int blk_codes[1];

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule